// File: doc/BRIEF.md
# Power-Up Strap Capture and Pin Role Sequencer

This block turns two shared pins from configuration inputs into clock outputs once after each power-up. While the supply is absent, every register is held cleared. When the supply-good indication rises, a window timer starts and runs for a set number of reference clock cycles. For the whole window both pin output enables stay low, so external strap resistors alone set the pin levels. Each pin level passes through a two-flop synchronizer.

When the window closes, the synchronized levels are captured into a strap register. A low level stores 0 and a high level stores 1. In the same cycle both output enables rise. The first pin then carries either a 24 MHz or a 48 MHz clock, chosen by the strap captured on the second pin. The second pin carries a copy of the reference clock. The captured bits go to the rest of the chip: bit 0 is a frequency-select strap and bit 1 is the 24/48 choice.

The captured bits and the done flag are cleared only when supply-good drops. No other event disturbs them.

Top module: `strap_sampler`

## Requirements
- R1: While `supply_good` is low, `pad_oe`, `pad_drive`, `strap_bits`, `sel_24` and `done` are all 0. Dropping `supply_good` clears them at once, without waiting for a clock edge.
- R2: After `supply_good` rises, `pad_oe` stays 2'b00 and `pad_drive` stays 2'b00 through the first WINDOW_CYCLES-1 rising edges of `clk`. At the WINDOW_CYCLES-th rising edge, both bits of `pad_oe` rise.
- R3: `strap_bits[0]` is captured from `pad_level[0]` and `strap_bits[1]` from `pad_level[1]`. Each captured bit equals the pin level at rising edge WINDOW_CYCLES-2, counted from the rise of `supply_good`. Low gives 0 and high gives 1.
- R4: After capture, changes on `pad_level` leave `strap_bits` unchanged for as long as `supply_good` stays high.
- R5: When the output is enabled, `pad_drive[0]` follows `clk_48` if `strap_bits[1]` is 0 and follows `clk_24` if it is 1. `sel_24` equals `strap_bits[1]`.
- R6: When the output is enabled, `pad_drive[1]` follows `clk_ref`.
- R7: `done` rises in the same cycle as `pad_oe`, rises only once per power-up, and stays high until `supply_good` falls.
- R8: A new rise of `supply_good` after a power loss restarts the window and captures fresh strap levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that runs the timer |
| supply_good | input | 1 | Supply-good indication; low acts as an asynchronous power-on clear |
| pad_level | input | 2 | Levels read back from the two shared pins |
| clk_24 | input | 1 | 24 MHz clock source |
| clk_48 | input | 1 | 48 MHz clock source |
| clk_ref | input | 1 | Reference clock copy source |
| pad_oe | output | 2 | Output buffer enables for the two pins |
| pad_drive | output | 2 | Data driven onto the two pins when enabled |
| strap_bits | output | 2 | Captured strap values |
| sel_24 | output | 1 | High when the first pin carries the 24 MHz clock |
| done | output | 1 | High once the window has closed |

## Verification
The bench goes after the last instant at which a pin change can still reach the captured value. It moves a pin one edge before that instant and one edge after it. A design with a missing or extra synchronizer stage would latch the wrong level in one of the two cases. The bench also checks the enable timing on the edge before the window ends and on the closing edge itself, which catches a timer that is one cycle off. After capture it toggles the pins, which exposes a register that keeps loading. Finally it drops the supply in mid-cycle and powers up again with new straps, which catches a design whose clear is synchronous or that keeps stale bits.

// File: rtl/strapseq_pkg.sv
package strapseq_pkg;

  typedef enum logic {
    PICK_48 = 1'b0,
    PICK_24 = 1'b1
  } half_sel_e;

  // Counter width needed to hold values 0 .. cycles
  function automatic int unsigned window_cnt_width(int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction

  // True in the cycle whose rising edge closes the window
  function automatic logic window_last(int unsigned count, int unsigned cycles);
    return count == (cycles - 1);
  endfunction

  // Maps the captured 24/48 strap to a clock choice
  function automatic half_sel_e half_pick(logic strap_level);
    return strap_level ? PICK_24 : PICK_48;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             supply_good,
  input  logic [WIDTH-1:0] pad_level,
  output logic [WIDTH-1:0] synced
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge supply_good) begin
      if (!supply_good) chain <= '0;
      else              chain <= {chain[STAGES-2:0], pad_level[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer
  import strapseq_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic supply_good,
  output logic window_open,
  output logic window_fire
);

  localparam int unsigned CW = window_cnt_width(WINDOW_CYCLES);

  logic [CW-1:0] cnt;
  logic          running;

  assign window_open = running;
  assign window_fire = running && window_last(32'(cnt), WINDOW_CYCLES);

  always_ff @(posedge clk or negedge supply_good) begin
    if (!supply_good) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (window_fire) running <= 1'b0;
      else             cnt     <= cnt + 1'b1;
    end
  end

  // R2: the closing edge ends the window for good
  p_fire_closes_r2: assert property (@(posedge clk) disable iff (!supply_good)
    window_fire |=> !window_open);

  // R7: no second closing pulse in one power-up
  p_fire_single_r7: assert property (@(posedge clk) disable iff (!supply_good)
    !window_open |=> !window_fire);

endmodule

// File: rtl/strap_latch_bank.sv
module strap_latch_bank #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             supply_good,
  input  logic             capture,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge supply_good) begin
      if (!supply_good) q[g] <= 1'b0;
      else if (capture) q[g] <= d[g];
    end
  end

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strapseq_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 28636,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       supply_good,
  input  logic [1:0] pad_level,
  input  logic       clk_24,
  input  logic       clk_48,
  input  logic       clk_ref,
  output logic [1:0] pad_oe,
  output logic [1:0] pad_drive,
  output logic [1:0] strap_bits,
  output logic       sel_24,
  output logic       done
);

  localparam int unsigned NSTRAP = 2;
  localparam int unsigned IDX_HALF = 1;

  logic              window_open;
  logic              window_fire;
  logic [NSTRAP-1:0] synced;
  logic              done_q;
  half_sel_e         half_sel;

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) timer_i (
    .clk         (clk),
    .supply_good (supply_good),
    .window_open (window_open),
    .window_fire (window_fire)
  );

  strap_sync #(.WIDTH(NSTRAP), .STAGES(SYNC_STAGES)) sync_i (
    .clk         (clk),
    .supply_good (supply_good),
    .pad_level   (pad_level),
    .synced      (synced)
  );

  strap_latch_bank #(.WIDTH(NSTRAP)) latch_i (
    .clk         (clk),
    .supply_good (supply_good),
    .capture     (window_fire),
    .d           (synced),
    .q           (strap_bits)
  );

  always_ff @(posedge clk or negedge supply_good) begin
    if (!supply_good)     done_q <= 1'b0;
    else if (window_fire) done_q <= 1'b1;
  end

  assign done     = done_q;
  assign pad_oe   = {NSTRAP{done_q}};
  assign half_sel = half_pick(strap_bits[IDX_HALF]);
  assign sel_24   = (half_sel == PICK_24);

  assign pad_drive[0] = done_q & ((half_sel == PICK_24) ? clk_24 : clk_48);
  assign pad_drive[1] = done_q & clk_ref;

  // R2: buffers stay three-stated while the timer is running
  p_quiet_window_r2: assert property (@(posedge clk) disable iff (!supply_good)
    window_open |-> (pad_oe == 2'b00));

  // R7: done rises only on the timer's closing edge
  p_done_edge_r7: assert property (@(posedge clk) disable iff (!supply_good)
    $rose(done) |-> $past(window_fire));

  // R7: done stays high
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!supply_good)
    done |=> done);

  // R4: captured straps frozen after the window
  p_strap_hold_r4: assert property (@(posedge clk) disable iff (!supply_good)
    done |=> $stable(strap_bits));

endmodule

// File: tb/strap_sampler_tb_top.sv
module strap_sampler_tb_top;

  localparam int W = 12;

  logic       clk = 1'b0;
  logic       supply_good;
  logic [1:0] pad_level;
  logic       clk_24, clk_48, clk_ref;
  logic [1:0] pad_oe, pad_drive, strap_bits;
  logic       sel_24, done;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string      req;
    string      what;
    logic [7:0] exp;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #2 clk = ~clk;

  strap_sampler #(.WINDOW_CYCLES(W), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .supply_good (supply_good),
    .pad_level   (pad_level),
    .clk_24      (clk_24),
    .clk_48      (clk_48),
    .clk_ref     (clk_ref),
    .pad_oe      (pad_oe),
    .pad_drive   (pad_drive),
    .strap_bits  (strap_bits),
    .sel_24      (sel_24),
    .done        (done)
  );

  // Driver side: push expected item
  task automatic expect_val(string req, string what, logic [7:0] exp);
    exp_item_t it;
    it.req = req; it.what = what; it.exp = exp;
    sb_q.push_back(it);
  endtask

  // Monitor side: pop and compare with observed value
  task automatic observe(logic [7:0] act);
    exp_item_t it;
    if (sb_q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard underflow actual=%0h expected=none", act);
      return;
    end
    it = sb_q.pop_front();
    checks++;
    if (act !== it.exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", it.req, it.what, act, it.exp);
    end
  endtask

  task automatic chk(string req, string what, logic [7:0] exp, logic [7:0] act);
    expect_val(req, what, exp);
    observe(act);
  endtask

  task automatic check_cleared(string req);
    chk(req, "pad_oe", 8'(2'b00), 8'(pad_oe));
    chk(req, "pad_drive", 8'(2'b00), 8'(pad_drive));
    chk(req, "strap_bits", 8'(2'b00), 8'(strap_bits));
    chk(req, "done", 8'(0), 8'(done));
    chk(req, "sel_24", 8'(0), 8'(sel_24));
  endtask

  // Rise supply at a negedge, count edges, change straps after edge sw_after
  task automatic power_up(logic [1:0] first, logic [1:0] second, int sw_after);
    @(negedge clk);
    pad_level   = first;
    supply_good = 1'b1;
    for (int n = 1; n <= W; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == sw_after) pad_level = second;
      if (n < W) begin
        chk("R2", "pad_oe in window", 8'(2'b00), 8'(pad_oe));
        if (n == W - 1) begin
          chk("R2", "pad_drive at W-1", 8'(2'b00), 8'(pad_drive));
          chk("R7", "done at W-1", 8'(0), 8'(done));
        end
      end else begin
        chk("R2", "pad_oe at W", 8'(2'b11), 8'(pad_oe));
        chk("R7", "done at W", 8'(1), 8'(done));
      end
    end
  endtask

  task automatic power_down();
    @(posedge clk);
    #1 supply_good = 1'b0;
    #0.5;
    check_cleared("R1");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    supply_good = 1'b0;
    pad_level   = 2'b11;
    clk_24 = 1'b1; clk_48 = 1'b1; clk_ref = 1'b1;
    repeat (3) @(negedge clk);
    check_cleared("R1");

    // Stable straps: FS strap low, 24/48 strap high
    power_up(2'b10, 2'b10, 0);
    chk("R3", "strap_bits stable 10", 8'(2'b10), 8'(strap_bits));
    chk("R5", "sel_24", 8'(1), 8'(sel_24));
    clk_24 = 1'b1; clk_48 = 1'b0; #0.5;
    chk("R5", "pin0 follows clk_24 high", 8'(1), 8'(pad_drive[0]));
    clk_24 = 1'b0; clk_48 = 1'b1; #0.5;
    chk("R5", "pin0 follows clk_24 low", 8'(0), 8'(pad_drive[0]));
    clk_ref = 1'b1; #0.5;
    chk("R6", "pin1 ref high", 8'(1), 8'(pad_drive[1]));
    clk_ref = 1'b0; #0.5;
    chk("R6", "pin1 ref low", 8'(0), 8'(pad_drive[1]));

    // Pin activity after capture
    pad_level = 2'b01;
    repeat (4) @(negedge clk);
    pad_level = 2'b11;
    repeat (4) @(negedge clk);
    chk("R4", "strap_bits after pin toggles", 8'(2'b10), 8'(strap_bits));
    chk("R7", "done stays high", 8'(1), 8'(done));

    // Mid-cycle power loss, then change just early enough to count
    power_down();
    power_up(2'b01, 2'b10, W - 3);
    chk("R8", "fresh capture after power cycle", 8'(2'b10), 8'(strap_bits));
    chk("R3", "late-but-in-time change captured", 8'(2'b10), 8'(strap_bits));

    // Change one edge too late: old level kept
    power_down();
    power_up(2'b00, 2'b11, W - 2);
    chk("R3", "too-late change ignored", 8'(2'b00), 8'(strap_bits));
    chk("R5", "sel_24 low", 8'(0), 8'(sel_24));
    clk_24 = 1'b0; clk_48 = 1'b1; #0.5;
    chk("R5", "pin0 follows clk_48 high", 8'(1), 8'(pad_drive[0]));
    clk_24 = 1'b1; clk_48 = 1'b0; #0.5;
    chk("R5", "pin0 follows clk_48 low", 8'(0), 8'(pad_drive[0]));

    // Both straps high
    power_down();
    power_up(2'b11, 2'b11, 0);
    chk("R3", "strap_bits 11", 8'(2'b11), 8'(strap_bits));
    chk("R8", "done after third power-up", 8'(1), 8'(done));

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule